// File: doc/BRIEF.md
# Compressed instruction expander

This block turns a 16-bit compressed instruction into the 32-bit base-format instruction that does the same work. It also raises a flag when the 16-bit code cannot be expanded. It is purely combinational and sits between instruction fetch and the main decoder. The decoder then sees only full-width words and the flag. A parameter selects a 32-bit or a 64-bit integer register width, and several encodings are legal only on the wider setting.

The input is a full 32-bit fetch word. When its two low bits are `11`, it is already a full instruction and goes through untouched. Otherwise only the low 16 bits are decoded and the upper half is ignored.

The block covers these instructions:
- the stack-pointer add with a wide immediate;
- word and doubleword loads and stores from quadrant 0;
- the quadrant-1 right shifts, and-immediate, register-register arithmetic, and the two branch-on-zero forms.

Every other 16-bit code is reported as illegal, and the output word is then forced to zero. The block has no clock, so it has no handshake; a result is valid in the same cycle as its input.

Top module: `cx_expander`

## Requirements
- R1: When instr_i[1:0] is 2'b11, expanded_o equals instr_i and illegal_o is 0.
- R2: A 3-bit register field with value r names integer register x(8+r). The field at bits 9:7 is the base, source 1, or destination-and-source. The field at bits 4:2 is the destination of a load or add, or source 2.
- R3: With quadrant 00 and funct3 000, the block yields addi rd, x2, imm. The unsigned immediate has bits 5:4 from instr[12:11], bits 9:6 from instr[10:7], bit 2 from instr[6] and bit 3 from instr[5]. An immediate of zero is illegal.
- R4: Quadrant 00 with funct3 010 gives lw rd, off(rs1), and funct3 110 gives sw rs2, off(rs1). The offset is unsigned, with bits 5:3 from instr[12:10], bit 2 from instr[6] and bit 6 from instr[5].
- R5: Quadrant 00 with funct3 011 gives ld, and funct3 111 gives sd. The offset has bits 5:3 from instr[12:10] and bits 7:6 from instr[6:5]. Both are legal only when XLEN is 64 and illegal when XLEN is 32.
- R6: Quadrant 01 with funct3 110 gives beq rs1, x0, off, and funct3 111 gives bne. The offset bits come from: 8 from instr[12], 4:3 from instr[11:10], 7:6 from instr[6:5], 2:1 from instr[4:3], and 5 from instr[2]. The offset is sign-extended from bit 8.
- R7: Quadrant 01 with funct3 100 uses instr[11:10] to pick the operation: 00 gives srli, 01 gives srai, 10 gives andi. The 6-bit value is {instr[12], instr[6:2]}, the register is rd=rs1, and the andi immediate is sign-extended.
- R8: On XLEN 32, a shift with instr[12]=1 is illegal; on XLEN 64 it is a legal shift by 32 to 63. A shift amount of zero expands to a shift by zero.
- R9: With instr[12:10]=011 in that group, instr[6:5] values 00, 01, 10 and 11 give sub, xor, or and and respectively, each in the form rd, rd, rs2.
- R10: With instr[12:10]=111, instr[6:5]=00 gives subw and 01 gives addw, both legal only on XLEN 64. The values 10 and 11 are illegal on both settings.
- R11: The all-zero word, every quadrant-10 code, and every funct3 not listed above are illegal.
- R12: Whenever illegal_o is 1, expanded_o is all zeros.
- R13: For a 16-bit code, instr_i[31:16] has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Fetched word; only the low half is decoded when bits 1:0 are not 11 |
| expanded_o | output | 32 | Equivalent full-width instruction, or zero when illegal |
| illegal_o | output | 1 | High when the 16-bit code has no expansion |

## Verification
The block holds no state, so any fault in the decode or the field placement shows at the ports in the same cycle as the input that reaches it. It affects only that input class: a misplaced offset bit changes the immediate fields of one load, store or branch form. A fault in the register window moves the rd, rs1 or rs2 field outside x8 to x15. Every low-half code is applied on both width settings, with a changing upper half. As a result, each such fault shows as a mismatch on the first code that exercises the faulty field, whether in the word or in the flag.

// File: rtl/cx_pkg.sv
package cx_pkg;

  typedef enum logic [2:0] {
    FMT_NONE,
    FMT_I,
    FMT_S,
    FMT_B,
    FMT_R
  } fmt_e;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OP32   = 7'b0111011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  localparam logic [6:0] F7_ALT = 7'b0100000;

  typedef struct packed {
    fmt_e        fmt;
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [12:0] imm;
  } uop_t;

endpackage

// File: rtl/cx_regwin.sv
module cx_regwin #(
  parameter int BASE = 8,
  parameter int FW   = 3,
  parameter int RW   = 5
) (
  input  logic [FW-1:0] field_i,
  output logic [RW-1:0] reg_o
);
  localparam logic [RW-1:0] BASE_V = RW'(BASE);

  assign reg_o = BASE_V + RW'(field_i);
endmodule

// File: rtl/cx_decode.sv
module cx_decode
  import cx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0] half_i,
  input  logic [4:0]  win_hi_i,
  input  logic [4:0]  win_lo_i,
  output uop_t        uop_o,
  output logic        bad_o
);
  localparam bit WIDE = (XLEN == 64);

  logic [2:0] f3;
  logic [9:0] spn_imm;
  logic [6:0] word_off;
  logic [7:0] dbl_off;
  logic [8:0] br_off;

  assign f3       = half_i[15:13];
  assign spn_imm  = {half_i[10:7], half_i[12:11], half_i[5], half_i[6], 2'b00};
  assign word_off = {half_i[5], half_i[12:10], half_i[6], 2'b00};
  assign dbl_off  = {half_i[6:5], half_i[12:10], 3'b000};
  assign br_off   = {half_i[12], half_i[6:5], half_i[2], half_i[11:10], half_i[4:3], 1'b0};

  always_comb begin
    uop_o = '0;
    uop_o.fmt = FMT_NONE;
    bad_o = 1'b1;
    case (half_i[1:0])
      2'b00: begin
        uop_o.rd  = win_lo_i;
        uop_o.rs2 = win_lo_i;
        uop_o.rs1 = win_hi_i;
        case (f3)
          3'b000: begin
            uop_o.fmt = FMT_I;
            uop_o.opc = OPC_OPIMM;
            uop_o.f3  = 3'b000;
            uop_o.rs1 = 5'd2;
            uop_o.imm = {3'b000, spn_imm};
            bad_o     = (spn_imm == 10'd0);
          end
          3'b010, 3'b110: begin
            uop_o.fmt = f3[2] ? FMT_S : FMT_I;
            uop_o.opc = f3[2] ? OPC_STORE : OPC_LOAD;
            uop_o.f3  = 3'b010;
            uop_o.imm = {6'd0, word_off};
            bad_o     = 1'b0;
          end
          3'b011, 3'b111: begin
            uop_o.fmt = f3[2] ? FMT_S : FMT_I;
            uop_o.opc = f3[2] ? OPC_STORE : OPC_LOAD;
            uop_o.f3  = 3'b011;
            uop_o.imm = {5'd0, dbl_off};
            bad_o     = !WIDE;
          end
          default: bad_o = 1'b1;
        endcase
      end
      2'b01: begin
        uop_o.rd  = win_hi_i;
        uop_o.rs1 = win_hi_i;
        uop_o.rs2 = win_lo_i;
        case (f3)
          3'b100: begin
            case (half_i[11:10])
              2'b00, 2'b01: begin
                uop_o.fmt = FMT_I;
                uop_o.opc = OPC_OPIMM;
                uop_o.f3  = 3'b101;
                uop_o.imm = {2'b00, half_i[10], 4'b0000, half_i[12], half_i[6:2]};
                bad_o     = half_i[12] && !WIDE;
              end
              2'b10: begin
                uop_o.fmt = FMT_I;
                uop_o.opc = OPC_OPIMM;
                uop_o.f3  = 3'b111;
                uop_o.imm = {{7{half_i[12]}}, half_i[12], half_i[6:2]};
                bad_o     = 1'b0;
              end
              default: begin
                uop_o.fmt = FMT_R;
                if (!half_i[12]) begin
                  uop_o.opc = OPC_OP;
                  case (half_i[6:5])
                    2'b00:   begin uop_o.f3 = 3'b000; uop_o.f7 = F7_ALT; end
                    2'b01:   uop_o.f3 = 3'b100;
                    2'b10:   uop_o.f3 = 3'b110;
                    default: uop_o.f3 = 3'b111;
                  endcase
                  bad_o = 1'b0;
                end else begin
                  uop_o.opc = OPC_OP32;
                  uop_o.f3  = 3'b000;
                  uop_o.f7  = half_i[5] ? 7'd0 : F7_ALT;
                  bad_o     = half_i[6] || !WIDE;
                end
              end
            endcase
          end
          3'b110, 3'b111: begin
            uop_o.fmt = FMT_B;
            uop_o.opc = OPC_BRANCH;
            uop_o.f3  = {2'b00, f3[0]};
            uop_o.rs2 = 5'd0;
            uop_o.imm = {{4{br_off[8]}}, br_off};
            bad_o     = 1'b0;
          end
          default: bad_o = 1'b1;
        endcase
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cx_encode.sv
module cx_encode
  import cx_pkg::*;
(
  input  uop_t        uop_i,
  output logic [31:0] word_o
);
  always_comb begin
    case (uop_i.fmt)
      FMT_I: word_o = {uop_i.imm[11:0], uop_i.rs1, uop_i.f3, uop_i.rd, uop_i.opc};
      FMT_S: word_o = {uop_i.imm[11:5], uop_i.rs2, uop_i.rs1, uop_i.f3,
                       uop_i.imm[4:0], uop_i.opc};
      FMT_B: word_o = {uop_i.imm[12], uop_i.imm[10:5], uop_i.rs2, uop_i.rs1,
                       uop_i.f3, uop_i.imm[4:1], uop_i.imm[11], uop_i.opc};
      FMT_R: word_o = {uop_i.f7, uop_i.rs2, uop_i.rs1, uop_i.f3, uop_i.rd, uop_i.opc};
      default: word_o = 32'd0;
    endcase
  end
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_BASE = 8
) (
  input  logic [31:0] instr_i,
  output logic [31:0] expanded_o,
  output logic        illegal_o
);
  localparam int NFIELD = 2;
  localparam int FW     = 3;
  localparam int RW     = 5;

  logic [RW-1:0] win [NFIELD];
  uop_t          uop;
  logic          bad;
  logic [31:0]   enc_word;
  logic          full_word;

  for (genvar g = 0; g < NFIELD; g++) begin : g_win
    localparam int LSB = (g == 0) ? 7 : 2;
    cx_regwin #(.BASE(REG_BASE), .FW(FW), .RW(RW)) u_win (
      .field_i(instr_i[LSB +: FW]),
      .reg_o  (win[g])
    );
  end

  cx_decode #(.XLEN(XLEN)) u_dec (
    .half_i  (instr_i[15:0]),
    .win_hi_i(win[0]),
    .win_lo_i(win[1]),
    .uop_o   (uop),
    .bad_o   (bad)
  );

  cx_encode u_enc (
    .uop_i (uop),
    .word_o(enc_word)
  );

  assign full_word  = (instr_i[1:0] == 2'b11);
  assign illegal_o  = !full_word && bad;
  assign expanded_o = full_word ? instr_i : (bad ? 32'd0 : enc_word);
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0] instr_i,
  input logic [31:0] expanded_o,
  input logic        illegal_o
);
  always_comb begin
    if (illegal_o)
      a_r12_zero_on_illegal: assert (expanded_o == 32'd0)
        else $error("R12 nonzero word with illegal flag");
    if (instr_i[1:0] == 2'b11)
      a_r1_pass_through: assert (expanded_o == instr_i && !illegal_o)
        else $error("R1 full word altered");
    if (instr_i[1:0] == 2'b10)
      a_r11_quadrant2_illegal: assert (illegal_o)
        else $error("R11 quadrant 2 accepted");
    if (XLEN == 32 && instr_i[1:0] == 2'b00 && instr_i[14:13] == 2'b11)
      a_r5_narrow_no_double: assert (illegal_o)
        else $error("R5 double access accepted on narrow width");
    if (!illegal_o && instr_i[1:0] == 2'b00 && !instr_i[15])
      a_r2_dest_in_window: assert (expanded_o[11:10] == 2'b01)
        else $error("R2 destination outside window");
    if (!illegal_o && instr_i[1:0] == 2'b01 && instr_i[15:14] == 2'b11)
      a_r6_branch_against_zero: assert (expanded_o[24:20] == 5'd0 &&
                                        expanded_o[6:0] == 7'b1100011)
        else $error("R6 branch not against x0");
  end
endmodule

bind cx_expander cx_expander_chk #(.XLEN(XLEN)) chk_i (
  .instr_i   (instr_i),
  .expanded_o(expanded_o),
  .illegal_o (illegal_o)
);

// File: tb/cx_expander_tb_top.sv
module cx_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic [31:0] out32, out64;
  logic        ill32, ill64;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cx_expander #(.XLEN(32)) dut_i   (.instr_i(instr), .expanded_o(out32), .illegal_o(ill32));
  cx_expander #(.XLEN(64)) dut64_i (.instr_i(instr), .expanded_o(out64), .illegal_o(ill64));

  typedef struct {
    logic [31:0] w;
    logic [31:0] x32;
    bit          i32;
    string       t32;
    logic [31:0] x64;
    bit          i64;
    string       t64;
  } item_t;

  item_t q[$];

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2,
                                        logic [4:0] rs1, logic [2:0] f3, logic [6:0] opc);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
  endfunction

  function automatic logic [31:0] enc_b(logic [12:0] imm, logic [4:0] rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], 5'd0, rs1, f3, imm[4:1], imm[11], 7'h63};
  endfunction

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  task automatic model(input logic [31:0] w, input bit rv64,
                       output logic [31:0] x, output bit ill, output string tag);
    logic [15:0] h = w[15:0];
    logic [4:0]  a = 5'(8 + int'(h[9:7]));
    logic [4:0]  b = 5'(8 + int'(h[4:2]));
    int          u;
    int          s;
    logic [2:0]  lf3;
    x = 32'd0; ill = 1'b1; tag = "R11";
    if (h[1:0] == 2'b11) begin
      x = w; ill = 1'b0; tag = "R1";
    end else if (h[1:0] == 2'b00) begin
      case (h[15:13])
        3'd0: begin
          tag = "R3";
          u = h[12:11] * 16 + h[10:7] * 64 + h[6] * 4 + h[5] * 8;
          if (u != 0) begin ill = 1'b0; x = enc_i(u[11:0], 5'd2, 3'd0, b, 7'h13); end
        end
        3'd2: begin
          tag = "R4"; ill = 1'b0;
          u = h[12:10] * 8 + h[6] * 4 + h[5] * 64;
          x = enc_i(u[11:0], a, 3'd2, b, 7'h03);
        end
        3'd6: begin
          tag = "R4"; ill = 1'b0;
          u = h[12:10] * 8 + h[6] * 4 + h[5] * 64;
          x = enc_s(u[11:0], b, a, 3'd2, 7'h23);
        end
        3'd3, 3'd7: begin
          tag = "R5";
          u = h[12:10] * 8 + h[6:5] * 64;
          if (rv64) begin
            ill = 1'b0;
            x = h[15] ? enc_s(u[11:0], b, a, 3'd3, 7'h23) : enc_i(u[11:0], a, 3'd3, b, 7'h03);
          end
        end
        default: tag = "R11";
      endcase
    end else if (h[1:0] == 2'b01) begin
      case (h[15:13])
        3'd4: begin
          case (h[11:10])
            2'd0, 2'd1: begin
              tag = (h[12] || h[6:2] == 5'd0) ? "R8" : "R7";
              u = h[12] * 32 + h[6:2] + (h[10] ? 1024 : 0);
              if (rv64 || !h[12]) begin ill = 1'b0; x = enc_i(u[11:0], a, 3'd5, a, 7'h13); end
            end
            2'd2: begin
              tag = "R7"; ill = 1'b0;
              s = h[12] ? int'(h[6:2]) - 32 : int'(h[6:2]);
              x = enc_i(s[11:0], a, 3'd7, a, 7'h13);
            end
            default: begin
              if (!h[12]) begin
                tag = "R9"; ill = 1'b0;
                case (h[6:5])
                  2'd0: lf3 = 3'd0;
                  2'd1: lf3 = 3'd4;
                  2'd2: lf3 = 3'd6;
                  default: lf3 = 3'd7;
                endcase
                x = enc_r((h[6:5] == 2'd0) ? 7'h20 : 7'h00, b, a, lf3, a, 7'h33);
              end else begin
                tag = "R10";
                if (rv64 && h[6:5] < 2'd2) begin
                  ill = 1'b0;
                  x = enc_r(h[5] ? 7'h00 : 7'h20, b, a, 3'd0, a, 7'h3b);
                end
              end
            end
          endcase
        end
        3'd6, 3'd7: begin
          tag = "R6"; ill = 1'b0;
          s = h[12] * 256 + h[11:10] * 8 + h[6:5] * 64 + h[4:3] * 2 + h[2] * 32;
          if (h[12]) s = s - 512;
          x = enc_b(s[12:0], a, {2'b00, h[13]});
        end
        default: tag = "R11";
      endcase
    end
  endtask

  task automatic drive(input logic [31:0] w, input string forced);
    item_t it;
    it.w = w;
    model(w, 1'b0, it.x32, it.i32, it.t32);
    model(w, 1'b1, it.x64, it.i64, it.t64);
    if (forced != "") begin it.t32 = forced; it.t64 = forced; end
    @(posedge clk);
    instr <= w;
    q.push_back(it);
  endtask

  task automatic compare(input string tag, input string side, input logic [31:0] w,
                         input logic [31:0] ax, input logic ai,
                         input logic [31:0] ex, input bit ei);
    checks++;
    if (ax !== ex || ai !== ei) begin
      failures++;
      $display("FAIL %s %s in=%08h actual=%08h/%0b expected=%08h/%0b",
               tag, side, w, ax, ai, ex, ei);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compare(it.t32, "xlen32", it.w, out32, ill32, it.x32, it.i32);
      compare(it.t64, "xlen64", it.w, out64, ill64, it.x64, it.i64);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: all-zero input held during reset is illegal with a zero word
    compare("R11", "reset32", instr, out32, ill32, 32'd0, 1'b1);
    compare("R11", "reset64", instr, out64, ill64, 32'd0, 1'b1);
    rst_n = 1'b1;
    // R2: rd field 7 must land on x15, base field 0 on x8
    drive({16'h0000, 16'h401C}, "R2");
    // R13: same low half under two different upper halves
    drive({16'hFFFF, 16'h401C}, "R13");
    drive({16'h1234, 16'h9C25}, "R13");
    // R8: shift by zero hint
    drive({16'h0000, 16'h8001}, "R8");
    // R12: zero word under a busy upper half
    drive({16'hFFFF, 16'h0000}, "R12");
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] lo = 16'(i);
      drive({~lo[7:0], lo[15:8] ^ 8'h5A, lo}, "");
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired with %0d items pending", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule